// File: doc/BRIEF.md
# Multi-Block Erase Selection Collector

This block collects the set of erase blocks to be cleared in one multi-block erase. The command decoder pulses `arm` once it has seen the confirming write of a block-erase sequence. From then on, every falling write-strobe edge loads the current address. The top three address bits pick one of eight block flags, and that flag is set. After each load, the rising strobe edge opens a response window of `WINDOW_CYC` clock cycles. If the next falling edge arrives inside that window, collection continues. If the window runs out first, loading closes.

When loading closes, the block presents the accumulated 8-bit selection mask and raises a single-cycle start pulse to the erase sequencer. It then holds the mask unchanged until the sequencer acknowledges it. An abort during loading discards all gathered flags, and no start pulse is issued. The window length is a parameter in clock cycles. The default stands for roughly 30 ms at 50 MHz, and simulation uses a short value.

Top module: `blk_erase_collector`

## Requirements
- R1: After reset, `erase_mask` is 0, `erase_start` is 0 and `loading` is 0.
- R2: A pulse on `arm` while idle sets `loading` from the next cycle. A falling strobe sampled in the same cycle as `arm`, or in any later cycle while loading, is loaded.
- R3: A load sets bit `addr[16:14]` of `erase_mask`, where bit n corresponds to index value n.
- R4: Every address from 1C000h to 1FFFFh sets bit 7, whatever `addr[13:12]` holds. The four small sub-blocks there share one flag.
- R5: Loading the same block index again leaves the mask as a single load would.
- R6: A falling strobe sampled on the WINDOW_CYC-th clock edge after the rising-edge sample is still loaded, and loading continues.
- R7: If no falling strobe is sampled within WINDOW_CYC edges after a rising-edge sample, the following edge clears `loading` and raises `erase_start` for exactly one cycle. A falling strobe sampled on that edge is not loaded.
- R8: Once `erase_start` has pulsed, `erase_mask` stays unchanged until `seq_ack`. `seq_ack` then clears the mask to 0 and returns the block to idle.
- R9: `abort` while loading clears the mask and `loading` on the next edge, and no `erase_start` follows.
- R10: Strobes while idle do not set flags. `arm` while the mask is held is ignored.
- R11: All eight flags can be selected in one collection, giving mask FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm | input | 1 | One-cycle pulse: block-erase confirm seen |
| abort | input | 1 | Discard the collection in progress |
| we_fall | input | 1 | One-cycle pulse: falling write-strobe edge |
| we_rise | input | 1 | One-cycle pulse: rising write-strobe edge |
| addr | input | 17 | Byte address presented with the strobe |
| seq_ack | input | 1 | Sequencer has taken the mask |
| erase_mask | output | 8 | Block selection flags |
| erase_start | output | 1 | One-cycle start request to the sequencer |
| loading | output | 1 | Collection window active |

## Verification
The properties take for granted that `we_fall` and `we_rise` are single-cycle pulses that alternate. They also assume `arm` arrives only while the block is idle or holding, and that `seq_ack` is raised only while the mask is held. The stimulus builds every strobe as a separate fall pulse and rise pulse, each one cycle wide. It pulses `arm` only between collections and pulses `seq_ack` only after `erase_start` has been observed. The one deliberate exception is the check that `arm` is ignored while holding, which the block's own hold rule absorbs.

// File: rtl/ecol_pkg.sv
package ecol_pkg;
  localparam int unsigned NBLK  = 8;
  localparam int unsigned IDX_W = $clog2(NBLK);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_HOLD = 2'd2
  } ecol_state_t;

  // Block index taken from the topmost address bits.
  function automatic logic [IDX_W-1:0] blk_index(input logic [16:0] a);
    return a[16 -: IDX_W];
  endfunction

  // One-hot selection for a block index.
  function automatic logic [NBLK-1:0] blk_onehot(input logic [IDX_W-1:0] i);
    return NBLK'(1) << i;
  endfunction
endpackage

// File: rtl/ecol_win_timer.sv
module ecol_win_timer #(
  parameter int unsigned WINDOW_CYC = 1_500_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic restart,
  input  logic stop,
  output logic expire
);
  localparam int unsigned CW = $clog2(WINDOW_CYC + 1);

  logic [CW-1:0] cnt;
  logic          run;

  assign expire = run && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (clr) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (restart) begin
      run <= 1'b1;
      cnt <= CW'(WINDOW_CYC);
    end else if (stop || expire) begin
      run <= 1'b0;
    end else if (run) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/ecol_flag_acc.sv
module ecol_flag_acc
  import ecol_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic [IDX_W-1:0] idx,
  output logic [NBLK-1:0]  flags
);
  logic [NBLK-1:0] sel;
  assign sel = blk_onehot(idx);

  for (genvar g = 0; g < NBLK; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                flags[g] <= 1'b0;
      else if (clr)              flags[g] <= 1'b0;
      else if (load && sel[g])   flags[g] <= 1'b1;
    end
  end
endmodule

// File: rtl/blk_erase_collector.sv
module blk_erase_collector
  import ecol_pkg::*;
#(
  parameter int unsigned WINDOW_CYC = 1_500_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        arm,
  input  logic        abort,
  input  logic        we_fall,
  input  logic        we_rise,
  input  logic [16:0] addr,
  input  logic        seq_ack,
  output logic [7:0]  erase_mask,
  output logic        erase_start,
  output logic        loading
);
  ecol_state_t state, state_nx;

  // Named internal events, also used by the checker.
  logic load_evt;
  logic win_expire;
  logic abort_evt;
  logic ack_evt;
  logic hold;
  logic flag_clr;

  assign loading   = (state == ST_LOAD);
  assign hold      = (state == ST_HOLD);
  assign abort_evt = loading && abort;
  assign ack_evt   = hold && seq_ack;
  assign flag_clr  = abort_evt || ack_evt;
  assign load_evt  = we_fall && !win_expire && !abort_evt &&
                     (loading || (state == ST_IDLE && arm));

  ecol_win_timer #(.WINDOW_CYC(WINDOW_CYC)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (abort_evt),
    .restart (loading && we_rise && !abort_evt),
    .stop    (load_evt),
    .expire  (win_expire)
  );

  ecol_flag_acc u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (flag_clr),
    .load  (load_evt),
    .idx   (blk_index(addr)),
    .flags (erase_mask)
  );

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE: if (arm)            state_nx = ST_LOAD;
      ST_LOAD: if (abort_evt)      state_nx = ST_IDLE;
               else if (win_expire) state_nx = ST_HOLD;
      ST_HOLD: if (seq_ack)        state_nx = ST_IDLE;
      default:                     state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      erase_start <= 1'b0;
    end else begin
      state       <= state_nx;
      erase_start <= loading && win_expire && !abort_evt;
    end
  end
endmodule

// File: rtl/blk_erase_collector_chk.sv
module blk_erase_collector_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       erase_start,
  input logic       loading,
  input logic [7:0] erase_mask,
  input logic       seq_ack,
  input logic       hold,
  input logic       win_expire,
  input logic       abort_evt,
  input logic       load_evt
);
  // R7
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |=> !erase_start);

  // R7
  expire_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_expire && !abort_evt) |=> (erase_start && !loading));

  // R11
  start_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> ($countones(erase_mask) > 0));

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !seq_ack) |=> $stable(erase_mask));

  // R9
  abort_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> (erase_mask == 8'h00 && !loading && !erase_start));

  // R3
  load_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> ($countones(erase_mask) > 0));
endmodule

bind blk_erase_collector blk_erase_collector_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .erase_start (erase_start),
  .loading     (loading),
  .erase_mask  (erase_mask),
  .seq_ack     (seq_ack),
  .hold        (hold),
  .win_expire  (win_expire),
  .abort_evt   (abort_evt),
  .load_evt    (load_evt)
);

// File: tb/blk_erase_collector_tb.sv
module blk_erase_collector_tb;
  localparam int unsigned WIN = 8;
  localparam int NV = 5;
  // {count[1:0], a0[16:0], a1[16:0], a2[16:0], expected mask[7:0]}
  localparam logic [60:0] VECS [0:NV-1] = '{
    {2'd1, 17'h04000, 17'h00000, 17'h00000, 8'h02},  // R3
    {2'd3, 17'h1C000, 17'h1D000, 17'h1F000, 8'h80},  // R4
    {2'd3, 17'h08000, 17'h08000, 17'h0BFFF, 8'h04},  // R5
    {2'd3, 17'h00000, 17'h14000, 17'h18000, 8'h61},  // R3
    {2'd2, 17'h0FFFF, 17'h10000, 17'h00000, 8'h18}   // R3
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arm = 1'b0, abort = 1'b0, we_fall = 1'b0, we_rise = 1'b0, seq_ack = 1'b0;
  logic [16:0] addr = '0;
  logic [7:0] erase_mask;
  logic erase_start, loading;
  int tests = 0, fails = 0, start_cnt = 0;

  always #4 clk = ~clk;

  blk_erase_collector #(.WINDOW_CYC(WIN)) u_dut (
    .clk(clk), .rst_n(rst_n), .arm(arm), .abort(abort), .we_fall(we_fall),
    .we_rise(we_rise), .addr(addr), .seq_ack(seq_ack),
    .erase_mask(erase_mask), .erase_start(erase_start), .loading(loading)
  );

  always @(posedge clk) if (erase_start) start_cnt <= start_cnt + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic fall(input logic [16:0] a);
    addr = a; we_fall = 1'b1; @(negedge clk); we_fall = 1'b0;
  endtask
  task automatic rise();
    we_rise = 1'b1; @(negedge clk); we_rise = 1'b0;
  endtask
  task automatic do_arm();
    arm = 1'b1; @(negedge clk); arm = 1'b0;
  endtask
  task automatic do_ack();
    seq_ack = 1'b1; @(negedge clk); seq_ack = 1'b0;
  endtask

  // After the last rise: check the window end, the start pulse and the mask.
  task automatic finish_window(input string req, input logic [7:0] exp);
    repeat (WIN) @(negedge clk);
    chk({req, " loading before expiry"}, loading, 1);
    @(negedge clk);
    chk({req, " start pulse"}, erase_start, 1);
    chk({req, " mask"}, erase_mask, exp);
    @(negedge clk);
    chk({req, " start one cycle"}, erase_start, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 mask", erase_mask, 0);
    chk("R1 start", erase_start, 0);
    chk("R1 loading", loading, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk
    for (int v = 0; v < NV; v++) begin
      base = start_cnt;
      do_arm();
      chk("R2 loading after arm", loading, 1);
      for (int k = 0; k < int'(VECS[v][60:59]); k++) begin
        fall(VECS[v][58-17*k -: 17]);
        rise();
      end
      finish_window("R3 table", VECS[v][7:0]);
      do_ack();
      chk("R8 ack clears mask", erase_mask, 0);
      chk("R8 back to idle", loading, 0);
      chk("R7 single start", start_cnt - base, 1);
    end

    // R10: strobes while idle are ignored
    fall(17'h04000); rise();
    repeat (WIN + 2) @(negedge clk);
    chk("R10 idle strobe no mask", erase_mask, 0);
    chk("R10 idle strobe no loading", loading, 0);
    // R2: fall sampled in the arm cycle is loaded
    addr = 17'h00000; arm = 1'b1; we_fall = 1'b1;
    @(negedge clk); arm = 1'b0; we_fall = 1'b0;
    rise();
    finish_window("R2 same-cycle load", 8'h01);
    do_ack();

    // R6: fall on the WIN-th edge after the rise is accepted
    do_arm();
    fall(17'h00000); rise();
    repeat (WIN - 1) @(negedge clk);
    chk("R6 still loading", loading, 1);
    fall(17'h04000);
    chk("R6 loading continues", loading, 1);
    rise();
    finish_window("R6 boundary load", 8'h03);
    do_ack();

    // R7: fall on the expiry edge is not loaded
    base = start_cnt;
    do_arm();
    fall(17'h08000); rise();
    repeat (WIN) @(negedge clk);
    chk("R7 loading at last edge", loading, 1);
    fall(17'h0C000);
    chk("R7 start at expiry", erase_start, 1);
    chk("R7 late fall ignored", erase_mask, 8'h04);
    chk("R7 loading dropped", loading, 0);
    // R8 hold stability, R10 arm ignored while holding
    repeat (5) @(negedge clk);
    do_arm();
    repeat (2) @(negedge clk);
    chk("R8 mask held", erase_mask, 8'h04);
    chk("R10 arm ignored in hold", loading, 0);
    chk("R7 exactly one start", start_cnt - base, 1);
    do_ack();
    chk("R8 mask cleared", erase_mask, 0);

    // R9: abort during loading
    base = start_cnt;
    do_arm();
    fall(17'h18000); rise();
    abort = 1'b1; @(negedge clk); abort = 1'b0;
    chk("R9 mask cleared", erase_mask, 0);
    chk("R9 loading cleared", loading, 0);
    repeat (WIN + 4) @(negedge clk);
    chk("R9 no start", start_cnt - base, 0);

    // R11: all eight flags
    do_arm();
    for (int b = 0; b < 8; b++) begin
      fall(17'(b) << 14);
      rise();
    end
    finish_window("R11 all blocks", 8'hFF);
    do_ack();

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule